// File: doc/BRIEF.md
# Vectorised Compare Predicate Generator

This block carries out one scalar compare that has been widened into a vector operation. A small lookup table marks register numbers as vector or scalar. When a compare starts, the block looks up both source registers in that table. If neither is a vector, it does an ordinary compare and reports a branch outcome one cycle later. If either one is a vector, the block walks through the elements one per clock. For each element, a vector source reads consecutive registers starting at its base number, and a scalar source keeps reading its base register. The result of element i sets bit i of a mask, and the full mask is written to a destination register of the internal register file in one final write.

The register file can be loaded from outside and read back through a debug port. The element count comes from a vector-length input and is capped at the data width, in the way a set-vector-length step takes the smaller of a request and a maximum. A scalar compare acts as a vector of length one whenever one of its sources is marked as a vector.

Top module: `vcmp_pred_unit`

## Requirements
- R1: The table has 8 entries, each holding a valid bit, a 5-bit key register number and a vector flag. A register counts as vectorised when the lowest-indexed valid entry whose key equals it has its flag set. A register with no valid matching entry is scalar.
- R2: When neither source is vectorised, `br_valid` is high for one cycle in the cycle after the start edge. In that cycle `br_taken` holds the compare of the two base registers. No register is written, `done` stays low and `busy` stays low.
- R3: For element i, a vectorised source reads register (base + i) modulo the register count, and a scalar source reads its base register.
- R4: In a vectorised compare, mask bit i equals the compare result of element i, and every bit at or above the element count is zero. The mask is written to the destination in one write. `done` goes high for one cycle VL+1 cycles after the first cycle following the start edge, and the new value is readable from that cycle on.
- R5: The `op` input selects the compare: 0 equal, 1 not equal, 2 signed less-than (a < b), 3 unsigned less-than (a < b).
- R6: A `vl` value above 32 is treated as 32.
- R7: A vectorised compare with `vl` = 0 writes an all-zero mask to the destination and raises `done` in the cycle right after the start edge.
- R8: A start pulse while `busy` is high is ignored. The running job keeps its destination and timing, and the destination named by the ignored pulse is left unchanged.
- R9: When an external load falls in the same cycle as the block's own mask write, the mask write takes effect and the external load is dropped.
- R10: After reset, `busy`, `done` and `br_valid` are low, all registers read zero and all table entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Write one lookup table entry |
| tbl_idx | input | 3 | Index of the table entry to write |
| tbl_valid | input | 1 | Valid bit of the written entry |
| tbl_key | input | 5 | Register number the entry describes |
| tbl_vec | input | 1 | Entry marks the register as a vector |
| ld_we | input | 1 | External register load enable |
| ld_addr | input | 5 | External load register number |
| ld_data | input | 32 | External load data |
| rd_addr | input | 5 | Debug read register number |
| rd_data | output | 32 | Debug read data (combinational) |
| start | input | 1 | Begin a compare (ignored while busy) |
| op | input | 2 | Compare kind |
| src_a | input | 5 | First source base register |
| src_b | input | 5 | Second source base register |
| dst | input | 5 | Destination register for the mask |
| vl | input | 6 | Requested element count |
| busy | output | 1 | Element loop or final write in progress |
| done | output | 1 | One-cycle pulse after the mask write |
| br_valid | output | 1 | One-cycle pulse carrying a scalar outcome |
| br_taken | output | 1 | Scalar compare result, valid with br_valid |

## Verification
Two functions can fall in the same cycle: the block's final mask write and an external register load, and the element loop and a fresh start pulse. The bench works out the cycle of the mask write from VL and drives a load there, once to an unrelated register and once to the destination itself. It expects the destination to hold the mask and the load's target to keep its old value. In another run it pulses start with a different destination in the middle of a loop. It then expects the original latency, a single done pulse, and an untouched second destination.

// File: rtl/vcmp_pkg.sv
// Shared types for the vectorised compare predicate generator.
// Assumes: no per-instance state lives here, only encodings.
package vcmp_pkg;

    // Compare kinds, fixed 2-bit encoding visible at the op port.
    typedef enum logic [1:0] {
        CMP_EQ  = 2'd0,
        CMP_NE  = 2'd1,
        CMP_LT  = 2'd2,
        CMP_LTU = 2'd3
    } cmp_op_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/vcmp_vec_table.sv
// Key-value table that marks register numbers as vector operands.
// Each entry holds valid, key and flag. Several entries may share a key.
// The lowest-indexed valid hit decides. NQ independent lookup ports.
// Assumes: writes happen one entry per cycle; lookups are combinational.
module vcmp_vec_table #(
    parameter int N  = 8,
    parameter int AW = 5,
    parameter int NQ = 2,
    localparam int TW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [TW-1:0]          widx,
    input  logic                   wvalid,
    input  logic [AW-1:0]          wkey,
    input  logic                   wvec,
    input  logic [NQ-1:0][AW-1:0]  q_key,
    output logic [NQ-1:0]          q_vec
);

    logic [N-1:0]          ent_v;
    logic [N-1:0]          ent_f;
    logic [N-1:0][AW-1:0]  ent_k;

    // Store one entry per write; reset invalidates all entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v <= '0;
            ent_f <= '0;
            ent_k <= '0;
        end else if (we) begin
            ent_v[widx] <= wvalid;
            ent_f[widx] <= wvec;
            ent_k[widx] <= wkey;
        end
    end

    for (genvar q = 0; q < NQ; q++) begin : g_port
        logic hit_flag;

        // Scan from the top down so the lowest matching index overrides.
        always_comb begin
            hit_flag = 1'b0;
            for (int e = N - 1; e >= 0; e--) begin
                if (ent_v[e] && (ent_k[e] == q_key[q])) begin
                    hit_flag = ent_f[e];
                end
            end
        end

        assign q_vec[q] = hit_flag;
    end

endmodule

// File: rtl/vcmp_regfile.sv
// Integer register file with three combinational read ports and one
// write port shared by the sequencer and an external loader.
// Assumes: the sequencer write has priority; a clashing load is dropped.
module vcmp_regfile #(
    parameter int NREG = 32,
    parameter int XLEN = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            int_we,
    input  logic [AW-1:0]   int_addr,
    input  logic [XLEN-1:0] int_data,
    input  logic            ext_we,
    input  logic [AW-1:0]   ext_addr,
    input  logic [XLEN-1:0] ext_data,
    input  logic [AW-1:0]   ra_addr,
    output logic [XLEN-1:0] ra_data,
    input  logic [AW-1:0]   rb_addr,
    output logic [XLEN-1:0] rb_data,
    input  logic [AW-1:0]   rc_addr,
    output logic [XLEN-1:0] rc_data
);

    logic [XLEN-1:0] mem [NREG];

    // Write the selected source; sequencer write wins over a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) mem[r] <= '0;
        end else if (int_we) begin
            mem[int_addr] <= int_data;
        end else if (ext_we) begin
            mem[ext_addr] <= ext_data;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
    assign rc_data = mem[rc_addr];

    // R9: a clash leaves the sequencer's data in the register.
    p_mask_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_we && ext_we) |=> (mem[$past(int_addr)] == $past(int_data)));

endmodule

// File: rtl/vcmp_alu.sv
// Combinational comparator for the four compare kinds.
// Assumes: operands are plain integers of the default element width.
module vcmp_alu #(
    parameter int XLEN = 32
) (
    input  vcmp_pkg::cmp_op_e op,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic              res
);

    // Select the compare named by op.
    always_comb begin
        unique case (op)
            vcmp_pkg::CMP_EQ:  res = (a == b);
            vcmp_pkg::CMP_NE:  res = (a != b);
            vcmp_pkg::CMP_LT:  res = ($signed(a) < $signed(b));
            vcmp_pkg::CMP_LTU: res = (a < b);
            default:           res = 1'b0;
        endcase
    end

endmodule

// File: rtl/vcmp_seq.sv
// Sequencer: accepts a start and chooses the scalar or vector path. It
// steps one element per cycle, collects the mask and issues the final write.
// Assumes: operand addresses feed combinational register reads and the
// compare result returns in the same cycle.
module vcmp_seq #(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    localparam int AW   = $clog2(NREG),
    localparam int VLW  = $clog2(XLEN + 1),
    localparam int IW   = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  vcmp_pkg::cmp_op_e op_i,
    input  logic [AW-1:0]     src_a_i,
    input  logic [AW-1:0]     src_b_i,
    input  logic [AW-1:0]     dst_i,
    input  logic [VLW-1:0]    vl_i,
    input  logic              vec_a_i,
    input  logic              vec_b_i,
    input  logic              cmp_res_i,
    output vcmp_pkg::cmp_op_e op_cur_o,
    output logic [AW-1:0]     addr_a_o,
    output logic [AW-1:0]     addr_b_o,
    output logic              int_we_o,
    output logic [AW-1:0]     int_addr_o,
    output logic [XLEN-1:0]   int_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              br_valid_o,
    output logic              br_taken_o
);
    import vcmp_pkg::*;

    seq_state_e         state;
    cmp_op_e            op_q;
    logic [AW-1:0]      base_a_q, base_b_q, dst_q;
    logic               vec_a_q, vec_b_q;
    logic [VLW-1:0]     vl_q, idx_q, eff_vl;
    logic [XLEN-1:0]    mask_q;
    logic               accept, any_vec;

    // Cap the requested length at the data width.
    assign eff_vl  = (vl_i > VLW'(XLEN)) ? VLW'(XLEN) : vl_i;
    assign accept  = start_i && (state == ST_IDLE);
    assign any_vec = vec_a_i || vec_b_i;
    assign busy_o  = (state != ST_IDLE);

    // Steer register reads: raw sources when idle, element addresses when running.
    always_comb begin
        if (state == ST_IDLE) begin
            addr_a_o = src_a_i;
            addr_b_o = src_b_i;
            op_cur_o = op_i;
        end else begin
            addr_a_o = vec_a_q ? (base_a_q + AW'(idx_q)) : base_a_q;
            addr_b_o = vec_b_q ? (base_b_q + AW'(idx_q)) : base_b_q;
            op_cur_o = op_q;
        end
    end

    // Drive the single mask write: final mask, or zero for an empty vector.
    always_comb begin
        int_we_o   = (state == ST_WRITE) || (accept && any_vec && (eff_vl == '0));
        int_addr_o = (state == ST_WRITE) ? dst_q : dst_i;
        int_data_o = (state == ST_WRITE) ? mask_q : '0;
    end

    // Advance the element loop and latch the job fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= CMP_EQ;
            base_a_q <= '0;
            base_b_q <= '0;
            dst_q    <= '0;
            vec_a_q  <= 1'b0;
            vec_b_q  <= 1'b0;
            vl_q     <= '0;
            idx_q    <= '0;
            mask_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept && any_vec && (eff_vl != '0)) begin
                        state    <= ST_RUN;
                        op_q     <= op_i;
                        base_a_q <= src_a_i;
                        base_b_q <= src_b_i;
                        dst_q    <= dst_i;
                        vec_a_q  <= vec_a_i;
                        vec_b_q  <= vec_b_i;
                        vl_q     <= eff_vl;
                        idx_q    <= '0;
                        mask_q   <= '0;
                    end
                end
                ST_RUN: begin
                    mask_q[idx_q[IW-1:0]] <= cmp_res_i;
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == vl_q - 1'b1) state <= ST_WRITE;
                end
                ST_WRITE: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Produce the completion and scalar branch pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            br_valid_o <= 1'b0;
            br_taken_o <= 1'b0;
        end else begin
            done_o     <= int_we_o;
            br_valid_o <= accept && !any_vec;
            br_taken_o <= accept && !any_vec && cmp_res_i;
        end
    end

    // R2: a scalar start never enters the loop.
    p_scalar_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !any_vec) |=> !busy_o);

    // R2: a branch outcome only follows an idle cycle.
    p_branch_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid_o |-> !$past(busy_o));

    // R4: the element index stays below the latched length.
    p_index_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (idx_q < vl_q));

    // R7: an empty vector completes on the next cycle.
    p_empty_vector_quick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && any_vec && (eff_vl == '0)) |=> (done_o && !busy_o));

    // R8: a running job keeps its destination and compare kind.
    p_job_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(dst_q) && $stable(op_q)));

endmodule

// File: rtl/vcmp_pred_unit.sv
// Top of the vectorised compare predicate generator. It ties the vector
// table, the register file, the comparator and the sequencer together.
// Assumes: one compare in flight; the register count is a power of two.
module vcmp_pred_unit #(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int TBL_N = 8,
    localparam int AW   = $clog2(NREG),
    localparam int TW   = $clog2(TBL_N),
    localparam int VLW  = $clog2(XLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tbl_we,
    input  logic [TW-1:0]   tbl_idx,
    input  logic            tbl_valid,
    input  logic [AW-1:0]   tbl_key,
    input  logic            tbl_vec,
    input  logic            ld_we,
    input  logic [AW-1:0]   ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [XLEN-1:0] rd_data,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [AW-1:0]   src_a,
    input  logic [AW-1:0]   src_b,
    input  logic [AW-1:0]   dst,
    input  logic [VLW-1:0]  vl,
    output logic            busy,
    output logic            done,
    output logic            br_valid,
    output logic            br_taken
);
    import vcmp_pkg::*;

    logic [1:0][AW-1:0] q_key;
    logic [1:0]         q_vec;
    cmp_op_e            op_cur;
    logic [AW-1:0]      addr_a, addr_b, int_addr;
    logic [XLEN-1:0]    opnd_a, opnd_b, int_data;
    logic               int_we, cmp_res;

    assign q_key[0] = src_a;
    assign q_key[1] = src_b;

    vcmp_vec_table #(.N(TBL_N), .AW(AW), .NQ(2)) i_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx),
        .wvalid(tbl_valid), .wkey(tbl_key), .wvec(tbl_vec),
        .q_key(q_key), .q_vec(q_vec)
    );

    vcmp_regfile #(.NREG(NREG), .XLEN(XLEN)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .int_we(int_we), .int_addr(int_addr), .int_data(int_data),
        .ext_we(ld_we), .ext_addr(ld_addr), .ext_data(ld_data),
        .ra_addr(addr_a), .ra_data(opnd_a),
        .rb_addr(addr_b), .rb_data(opnd_b),
        .rc_addr(rd_addr), .rc_data(rd_data)
    );

    vcmp_alu #(.XLEN(XLEN)) i_alu (
        .op(op_cur), .a(opnd_a), .b(opnd_b), .res(cmp_res)
    );

    vcmp_seq #(.XLEN(XLEN), .NREG(NREG)) i_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(cmp_op_e'(op)),
        .src_a_i(src_a), .src_b_i(src_b), .dst_i(dst), .vl_i(vl),
        .vec_a_i(q_vec[0]), .vec_b_i(q_vec[1]), .cmp_res_i(cmp_res),
        .op_cur_o(op_cur), .addr_a_o(addr_a), .addr_b_o(addr_b),
        .int_we_o(int_we), .int_addr_o(int_addr), .int_data_o(int_data),
        .busy_o(busy), .done_o(done), .br_valid_o(br_valid), .br_taken_o(br_taken)
    );

endmodule

// File: tb/test_vcmp_pred_unit.sv
`timescale 1ns/1ps
module test_vcmp_pred_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 0, tbl_valid = 0, tbl_vec = 0;
    logic [2:0]  tbl_idx = 0;
    logic [4:0]  tbl_key = 0;
    logic        ld_we = 0;
    logic [4:0]  ld_addr = 0, rd_addr = 0;
    logic [31:0] ld_data = 0, rd_data;
    logic        start = 0;
    logic [1:0]  op = 0;
    logic [4:0]  src_a = 0, src_b = 0, dst = 0;
    logic [5:0]  vl = 0;
    logic        busy, done, br_valid, br_taken;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [31:0] mreg [32];
    bit          tv [8];
    bit          tf [8];
    logic [4:0]  tk [8];

    always #10 clk = ~clk;   // 50 MHz

    vcmp_pred_unit i_vcmp_pred_unit (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_valid(tbl_valid), .tbl_key(tbl_key), .tbl_vec(tbl_vec),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .dst(dst), .vl(vl),
        .busy(busy), .done(done), .br_valid(br_valid), .br_taken(br_taken)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit is_vec(input logic [4:0] r);
        for (int e = 0; e < 8; e++)
            if (tv[e] && tk[e] == r) return tf[e];
        return 1'b0;
    endfunction

    function automatic bit cmpf(input logic [1:0] k, input logic [31:0] a, input logic [31:0] b);
        case (k)
            2'd0: return a == b;
            2'd1: return a != b;
            2'd2: return $signed(a) < $signed(b);
            default: return a < b;
        endcase
    endfunction

    task automatic load(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); ld_we = 1; ld_addr = a; ld_data = d;
        @(negedge clk); ld_we = 0;
        mreg[a] = d;
    endtask

    task automatic tbl_set(input int e, input bit v, input logic [4:0] k, input bit f);
        @(negedge clk); tbl_we = 1; tbl_idx = 3'(e); tbl_valid = v; tbl_key = k; tbl_vec = f;
        @(negedge clk); tbl_we = 0;
        tv[e] = v; tk[e] = k; tf[e] = f;
    endtask

    function automatic logic [31:0] peek(input logic [4:0] a);
        return mreg[a];
    endfunction

    // Runs one compare; optional start injection (alt_d) and load injection.
    task automatic run_op(input string tag, input logic [1:0] k, input logic [4:0] sa,
                          input logic [4:0] sb, input logic [4:0] d, input int len,
                          input int inj_s, input logic [4:0] alt_d,
                          input int inj_l, input logic [4:0] la, input logic [31:0] ldv);
        bit va, vb, exp_t;
        int ev, exp_c, c;
        logic [31:0] mask, old_alt, old_la;
        va = is_vec(sa); vb = is_vec(sb);
        ev = (len > 32) ? 32 : len;
        mask = 0; exp_t = 0;
        if (!va && !vb) begin
            exp_t = cmpf(k, mreg[sa], mreg[sb]);
            exp_c = 0;
        end else begin
            for (int i = 0; i < ev; i++)
                mask[i] = cmpf(k, va ? mreg[(sa + i) % 32] : mreg[sa],
                                  vb ? mreg[(sb + i) % 32] : mreg[sb]);
            exp_c = (ev == 0) ? 0 : ev + 1;
        end
        old_alt = mreg[alt_d]; old_la = mreg[la];
        @(negedge clk);
        start = 1; op = k; src_a = sa; src_b = sb; dst = d; vl = 6'(len);
        @(negedge clk);
        start = 0;
        c = 0;
        forever begin
            if (done || br_valid || c >= 200) break;
            start = (c == inj_s);
            dst   = (c == inj_s) ? alt_d : d;
            ld_we = (c == inj_l); ld_addr = la; ld_data = ldv;
            @(negedge clk);
            c++;
        end
        start = 0; ld_we = 0; dst = d;
        if (!va && !vb) begin
            check(br_valid && !done && c == 0, {tag, " R2 scalar timing"}, c, 0);
            check(br_taken == exp_t, {tag, " R2 branch result"}, br_taken, exp_t);
            check(!busy, {tag, " R2 no busy"}, busy, 0);
            rd_addr = d; #1;
            check(rd_data == mreg[d], {tag, " R2 dst untouched"}, rd_data, mreg[d]);
        end else begin
            check(done && !br_valid && c == exp_c, {tag, " R4 done latency"}, c, exp_c);
            rd_addr = d; #1;
            check(rd_data == mask, {tag, " R4 mask value"}, rd_data, mask);
            mreg[d] = mask;
            @(negedge clk);
            check(!done, {tag, " R4 done single pulse"}, done, 0);
        end
        if (inj_s >= 0 && alt_d != d) begin
            rd_addr = alt_d; #1;
            check(rd_data == old_alt, {tag, " R8 ignored start dst"}, rd_data, old_alt);
        end
        if (inj_l >= 0 && la != d) begin
            rd_addr = la; #1;
            check(rd_data == old_la, {tag, " R9 load dropped"}, rd_data, old_la);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] vals [5];
        void'($urandom(32'd2024));
        for (int r = 0; r < 32; r++) mreg[r] = 0;
        for (int e = 0; e < 8; e++) begin tv[e] = 0; tf[e] = 0; tk[e] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        check(!busy && !done && !br_valid, "R10 outputs idle", {busy, done, br_valid}, 0);
        rd_addr = 5'd17; #1;
        check(rd_data == 0, "R10 register cleared", rd_data, 0);
        // R10: table empty -> scalar path
        run_op("R10 empty table", 2'd0, 5'd3, 5'd4, 5'd20, 4, -1, 0, -1, 0, 0);

        // R1: overlapping keys, lowest index wins (entry0 scalar over entry1 vector)
        tbl_set(0, 1, 5'd3, 0);
        tbl_set(1, 1, 5'd3, 1);
        tbl_set(2, 0, 5'd4, 1);
        load(5'd3, 32'd7); load(5'd4, 32'd7);
        run_op("R1 overlap", 2'd0, 5'd3, 5'd4, 5'd20, 4, -1, 0, -1, 0, 0);
        tbl_set(0, 0, 5'd3, 0);
        run_op("R1 next match", 2'd0, 5'd3, 5'd4, 5'd20, 2, -1, 0, -1, 0, 0);

        // R3 / R5: vector a from reg 8, scalar b reg 2
        tbl_set(3, 1, 5'd8, 1);
        load(5'd8, 32'd1); load(5'd9, 32'hFFFF_FFFF); load(5'd10, 32'd5); load(5'd11, 32'd5);
        load(5'd2, 32'd5);
        for (int k = 0; k < 4; k++)
            run_op("R5 op kinds", 2'(k), 5'd8, 5'd2, 5'd21, 4, -1, 0, -1, 0, 0);
        // R3: wrap-around of the register number
        tbl_set(4, 1, 5'd30, 1);
        load(5'd30, 32'd9); load(5'd31, 32'd2); load(5'd0, 32'd9);
        run_op("R3 wrap", 2'd0, 5'd30, 5'd8, 5'd22, 5, -1, 0, -1, 0, 0);
        // R6: length above 32 capped
        run_op("R6 clamp", 2'd1, 5'd8, 5'd2, 5'd23, 45, -1, 0, -1, 0, 0);
        // R7: empty vector clears the destination
        load(5'd24, 32'hDEAD_BEEF);
        run_op("R7 vl zero", 2'd0, 5'd8, 5'd2, 5'd24, 0, -1, 0, -1, 0, 0);
        // R8: start while busy ignored
        load(5'd25, 32'h1234_5678);
        run_op("R8 busy start", 2'd3, 5'd8, 5'd2, 5'd26, 5, 2, 5'd25, -1, 0, 0);
        // R9: load colliding with the mask write (write cycle is c == VL)
        load(5'd27, 32'h0BAD_F00D);
        run_op("R9 other reg", 2'd2, 5'd8, 5'd2, 5'd28, 3, -1, 0, 3, 5'd27, 32'h5555_5555);
        run_op("R9 same reg", 2'd2, 5'd8, 5'd2, 5'd28, 3, -1, 0, 3, 5'd28, 32'h5555_5555);

        // Random mix
        vals[0] = 0; vals[1] = 1; vals[2] = 2; vals[3] = 32'hFFFF_FFFF; vals[4] = 32'h8000_0000;
        for (int it = 0; it < 60; it++) begin
            if (it % 10 == 0)
                for (int e = 0; e < 8; e++)
                    tbl_set(e, ($urandom % 4) != 0, 5'($urandom % 8), $urandom % 2);
            for (int r = 0; r < 8; r++) load(5'(r), vals[$urandom % 5]);
            run_op("random", 2'($urandom % 4), 5'($urandom % 8), 5'($urandom % 8),
                   5'(16 + $urandom % 16), $urandom % 41, -1, 0, -1, 0, 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule